// File: doc/BRIEF.md
# SPI Master Transmit Queue with Hysteresis Refill Flag

This block is the transmit half of an SPI master. Software writes data into a four-entry byte queue through a plain write port that takes either one byte or one 16-bit halfword per cycle. A shift engine takes bytes from the head of the queue and sends them in SPI mode 0, most significant bit first, at a serial clock rate set by a 4-bit divide field.

A refill flag tells software, through an interrupt line or a DMA request, when to put more data in. The flag has hysteresis. It turns on once the queue holds two bytes or fewer. After that it stays on until the queue is completely full, so a refill routine can keep writing until the flag drops. A second flag shows that everything has been sent: the queue is empty and the shift engine is idle.

A write that does not fit in the free space is discarded whole and sets a sticky error bit. Only reset clears that bit.

Top module: `spi_tx_queue_top`

## Requirements
- R1: The queue holds four byte entries. A byte write (`wr_half`=0) pushes `wr_data[7:0]`. A halfword write (`wr_half`=1) pushes `wr_data[7:0]` first and then `wr_data[15:8]`. Bytes go out on the wire in the order they were pushed.
- R2: `txe` is 1 whenever the queue holds two or fewer entries.
- R3: After it turns on, `txe` stays 1 until the queue holds four entries, and it reads 0 when the queue holds four. When the count then falls back to three, `txe` stays 0. It turns on again only when the count is two or fewer.
- R4: `irq` equals `txe` AND `irq_en`.
- R5: A halfword write with fewer than two free entries is discarded, and so is a byte write to a full queue. A discarded write adds no entry and none of its data is ever sent. It sets `ovf_err`, which stays 1 until reset.
- R6: `sclk` is low whenever the shift engine is idle. `mosi` changes only on a falling edge of `sclk` or when a new byte is loaded with `sclk` low. Each byte goes out MSB first and is valid at every rising edge.
- R7: One `sclk` period is 2*(`div`+1) system clock cycles.
- R8: When a byte's last bit completes and the queue is not empty, the next byte starts at once. The `sclk` period runs on without a break across the byte boundary.
- R9: `tx_empty` is 1 only when the queue holds no entries and no byte is being shifted.
- R10: `busy` is the inverse of `tx_empty`.
- R11: After a synchronous reset, `txe`=1, `tx_empty`=1, `busy`=0, `sclk`=0, `mosi`=0 and `ovf_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_half | input | 1 | 1 = halfword write, 0 = byte write |
| wr_data | input | 16 | Write data; low byte is pushed first |
| div | input | 4 | Serial clock divide field |
| irq_en | input | 1 | Enable for the refill interrupt |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| txe | output | 1 | Refill request flag with hysteresis |
| irq | output | 1 | Gated refill interrupt |
| tx_empty | output | 1 | Queue and shifter fully drained |
| busy | output | 1 | Transfer in progress or data queued |
| ovf_err | output | 1 | Sticky discarded-write error |

## Verification
An occupancy count that is off by one shows up at the ports within one cycle of a write. Either `txe` drops one write too early or too late, or a write that should have been discarded is accepted. The data then also comes out wrong on `mosi`, one byte time later. If the hysteresis state is lost, `txe` goes high again at three entries instead of two. That is visible one byte time after the queue was filled, which is 16*(`div`+1) cycles. A shifter that loses its place produces wrong bytes on `mosi` or a break in the `sclk` spacing at the next byte boundary. The bench captures both.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
    localparam int BYTE_W     = 8;
    localparam int QUEUE_DEPTH = 4;
    localparam int DIV_W      = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_BYTE = 2'd1,
        WR_HALF = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e kind;
        byte_t    lo;
        byte_t    hi;
    } wr_req_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    function automatic int slots_for(wr_kind_e k);
        case (k)
            WR_BYTE: return 1;
            WR_HALF: return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/spi_tx_queue.sv
module spi_tx_queue
    import spi_tx_pkg::*;
#(
    parameter int DEPTH = QUEUE_DEPTH,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       req,
    input  logic          pop,
    output byte_t         head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    byte_t         mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] count_q;
    logic          ovf_q;

    logic [CW-1:0] need, free_slots, add;
    logic          accept, drop, pop_ok;
    logic [PW-1:0] wp_n1, wp_n2, rp_n1;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        need       = CW'(slots_for(req.kind));
        free_slots = CW'(DEPTH) - count_q;
        accept     = (need != '0) && (need <= free_slots);
        drop       = (need != '0) && (need > free_slots);
        pop_ok     = pop && (count_q != '0);
        add        = accept ? need : '0;
        wp_n1      = step(wp_q);
        wp_n2      = step(wp_n1);
        rp_n1      = step(rp_q);
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wp_q] <= req.lo;
            if (req.kind == WR_HALF) mem[wp_n1] <= req.hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (accept) wp_q <= (req.kind == WR_HALF) ? wp_n2 : wp_n1;
            if (pop_ok) rp_q <= rp_n1;
            count_q <= count_q + add - CW'(pop_ok);
            ovf_q   <= ovf_q | drop;
        end
    end

    assign head  = mem[rp_q];
    assign count = count_q;
    assign ovf   = ovf_q;

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    p_drop_no_add_r5: assert property (@(posedge clk) disable iff (rst)
        (drop && !pop_ok) |=> $stable(count_q));
endmodule

// File: rtl/spi_tx_refill_flag.sv
module spi_tx_refill_flag
    import spi_tx_pkg::*;
#(
    parameter int DEPTH = QUEUE_DEPTH,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic          irq_en,
    output logic          txe,
    output logic          irq
);
    logic armed_q;

    always_comb begin
        txe = (count <= CW'(HALF)) || (armed_q && (count != CW'(DEPTH)));
        irq = txe && irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
        else     armed_q <= txe;
    end

    p_txe_low_half_r2: assert property (@(posedge clk) disable iff (rst)
        (count <= CW'(HALF)) |-> txe);
    p_txe_hold_r3: assert property (@(posedge clk) disable iff (rst)
        txe |=> (txe || count == CW'(DEPTH)));
    p_txe_full_r3: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !txe);
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_tx_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int DW = DIV_W,
    localparam int BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div,
    input  logic          have_data,
    input  logic [W-1:0]  head,
    output logic          pop,
    output logic          sclk,
    output logic          mosi,
    output logic          active
);
    sh_state_e     state_q;
    logic [DW-1:0] div_cnt_q;
    logic [BW-1:0] bit_q;
    logic [W-1:0]  sh_q;
    logic          sclk_q;
    logic          tick, last_fall;

    always_comb begin
        tick      = (div_cnt_q == div);
        last_fall = (state_q == SH_RUN) && tick && sclk_q && (bit_q == BW'(W - 1));
        pop       = ((state_q == SH_IDLE) && have_data) || (last_fall && have_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SH_IDLE;
            div_cnt_q <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            sclk_q    <= 1'b0;
        end else begin
            case (state_q)
                SH_IDLE: begin
                    sclk_q <= 1'b0;
                    if (have_data) begin
                        sh_q      <= head;
                        state_q   <= SH_RUN;
                        div_cnt_q <= '0;
                        bit_q     <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        div_cnt_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == BW'(W - 1)) begin
                                bit_q <= '0;
                                if (have_data) sh_q <= head;
                                else           state_q <= SH_IDLE;
                            end else begin
                                sh_q  <= sh_q << 1;
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        div_cnt_q <= div_cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign sclk   = sclk_q;
    assign mosi   = (state_q == SH_RUN) ? sh_q[W-1] : 1'b0;
    assign active = (state_q == SH_RUN);

    p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk);
    p_mosi_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
        sclk |=> (!sclk || $stable(mosi)));
    p_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
        (active && pop) |=> active);
endmodule

// File: rtl/spi_tx_queue_top.sv
module spi_tx_queue_top
    import spi_tx_pkg::*;
#(
    parameter int DEPTH = QUEUE_DEPTH,
    parameter int DW = DIV_W,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_half,
    input  logic [15:0]   wr_data,
    input  logic [DW-1:0] div,
    input  logic          irq_en,
    output logic          sclk,
    output logic          mosi,
    output logic          txe,
    output logic          irq,
    output logic          tx_empty,
    output logic          busy,
    output logic          ovf_err
);
    wr_req_t       req;
    byte_t         head;
    logic [CW-1:0] count;
    logic          pop, active;

    always_comb begin
        req.kind = !wr_en ? WR_NONE : (wr_half ? WR_HALF : WR_BYTE);
        req.lo   = wr_data[7:0];
        req.hi   = wr_data[15:8];
    end

    spi_tx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .req(req), .pop(pop),
        .head(head), .count(count), .ovf(ovf_err)
    );

    spi_tx_refill_flag #(.DEPTH(DEPTH)) u_flag (
        .clk(clk), .rst(rst), .count(count), .irq_en(irq_en),
        .txe(txe), .irq(irq)
    );

    spi_tx_shifter #(.W(BYTE_W), .DW(DW)) u_shift (
        .clk(clk), .rst(rst), .div(div), .have_data(count != '0),
        .head(head), .pop(pop), .sclk(sclk), .mosi(mosi), .active(active)
    );

    assign tx_empty = (count == '0) && !active;
    assign busy     = !tx_empty;

    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (!sclk && !mosi));
endmodule

// File: tb/spi_tx_queue_tb.sv
module spi_tx_queue_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_half = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  div = '0;
    logic        irq_en = 1'b0;
    logic        sclk, mosi, txe, irq, tx_empty, busy, ovf_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_tx_queue_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_half(wr_half),
        .wr_data(wr_data), .div(div), .irq_en(irq_en), .sclk(sclk),
        .mosi(mosi), .txe(txe), .irq(irq), .tx_empty(tx_empty),
        .busy(busy), .ovf_err(ovf_err)
    );

    // serial capture: shift in on each rising sclk edge, log edge times
    logic [7:0] cap_sh = '0;
    logic [7:0] captured [64];
    time        rise_t [256];
    int         nrise = 0, ncap = 0;

    always @(posedge sclk) begin
        cap_sh = {cap_sh[6:0], mosi};
        if (nrise < 256) rise_t[nrise] = $time;
        nrise = nrise + 1;
        if (nrise % 8 == 0 && ncap < 64) begin
            captured[ncap] = cap_sh;
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input bit half, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_half = half; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cap(input int n);
        for (int g = 0; g < 20000 && ncap < n; g++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 20000 && !tx_empty; g++) @(negedge clk);
    endtask

    // vector table: {div[3:0], byte[7:0]}
    localparam logic [11:0] VEC [4] = '{12'h0A5, 12'h13C, 12'h381, 12'h2F0};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(txe == 1'b1, "R11 txe", txe, 1);
        chk(tx_empty == 1'b1 && busy == 1'b0, "R11 empty/busy", {tx_empty, busy}, 2'b10);
        chk(sclk == 1'b0 && mosi == 1'b0, "R11 sclk/mosi", {sclk, mosi}, 0);
        chk(ovf_err == 1'b0, "R11 ovf", ovf_err, 0);
        chk(irq == 1'b0, "R4 irq gated off", irq, 0);

        // table walk: single bytes at different divides
        foreach (VEC[i]) begin
            int base_r, base_c;
            base_r = nrise; base_c = ncap;
            @(negedge clk); div = VEC[i][11:8];
            put(1'b0, {8'h00, VEC[i][7:0]});
            chk(tx_empty == 1'b0 && busy == 1'b1, "R9 R10 queued", {tx_empty, busy}, 2'b01);
            wait_idle();
            chk(ncap == base_c + 1, "R1 byte count", ncap - base_c, 1);
            chk(captured[base_c] == VEC[i][7:0], "R6 MSB-first data", captured[base_c], VEC[i][7:0]);
            chk(rise_t[base_r+1] - rise_t[base_r] == 64'(16 * (VEC[i][11:8] + 1)),
                "R7 sclk period", rise_t[base_r+1] - rise_t[base_r], 16 * (VEC[i][11:8] + 1));
            chk(sclk == 1'b0, "R6 idle low", sclk, 0);
        end

        // hysteresis, overflow, ordering, back-to-back
        begin
            int base_r, base_c;
            base_r = nrise; base_c = ncap;
            chk(ovf_err == 1'b0, "R5 no overflow yet", ovf_err, 0);
            @(negedge clk); div = 4'd15;
            @(negedge clk); wr_en = 1'b1; wr_half = 1'b1; wr_data = 16'h2211;
            @(negedge clk); wr_data = 16'h4433;
            @(negedge clk); wr_en = 1'b0;
            // count 3 after one pop: hysteresis keeps txe
            chk(txe == 1'b1, "R3 hold above half", txe, 1);
            put(1'b1, 16'h7766);
            chk(ovf_err == 1'b1, "R5 half drop sets ovf", ovf_err, 1);
            chk(txe == 1'b1, "R5 dropped half adds nothing", txe, 1);
            put(1'b0, 16'h0055);
            chk(txe == 1'b0, "R3 clear at full", txe, 0);
            put(1'b0, 16'h0099);
            chk(txe == 1'b0, "R3 full stays clear", txe, 0);
            wait_cap(base_c + 1);
            repeat (20) @(negedge clk);
            chk(txe == 1'b0, "R3 no re-arm at three", txe, 0);
            chk(irq == 1'b0, "R4 irq low while txe low", irq, 0);
            wait_cap(base_c + 2);
            repeat (20) @(negedge clk);
            chk(txe == 1'b1, "R2 re-arm at two", txe, 1);
            wait_cap(base_c + 4);
            repeat (20) @(negedge clk);
            chk(tx_empty == 1'b0 && busy == 1'b1, "R9 R10 last byte shifting", {tx_empty, busy}, 2'b01);
            wait_idle();
            chk(ncap == base_c + 5, "R5 dropped data not sent", ncap - base_c, 5);
            chk(captured[base_c]   == 8'h11, "R1 order 0", captured[base_c],   8'h11);
            chk(captured[base_c+1] == 8'h22, "R1 order 1", captured[base_c+1], 8'h22);
            chk(captured[base_c+2] == 8'h33, "R1 order 2", captured[base_c+2], 8'h33);
            chk(captured[base_c+3] == 8'h44, "R1 order 3", captured[base_c+3], 8'h44);
            chk(captured[base_c+4] == 8'h55, "R1 order 4", captured[base_c+4], 8'h55);
            chk(rise_t[base_r+8] - rise_t[base_r+7] == 64'd256, "R8 no gap",
                rise_t[base_r+8] - rise_t[base_r+7], 256);
            chk(ovf_err == 1'b1, "R5 ovf sticky", ovf_err, 1);
        end

        chk(irq == 1'b0, "R4 irq disabled", irq, 0);
        @(negedge clk); irq_en = 1'b1;
        #1;
        chk(irq == 1'b1, "R4 irq enabled", irq, 1);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(ovf_err == 1'b0, "R5 R11 reset clears ovf", ovf_err, 0);
        chk(txe == 1'b1 && tx_empty == 1'b1, "R11 flags after reset", {txe, tx_empty}, 2'b11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule